// File: doc/BRIEF.md
# Dual Port Memory Access Arbiter

This block shares one 1 KB byte-wide memory between two independent command ports: a contactless radio front-end port (RF) and a wired two-wire serial bus port (SB). Each port issues single-byte reads and writes through a request interface. The block grants the memory to one port at a time and keeps that grant for the whole operation. Before any access it checks the request against a 16-byte protection page. That page holds per-port rights for each memory block, write locks for the pages of block 0, and a tamper flag. The flag lets the wired side notice that the radio side has used the memory.

The memory has 8 blocks. Each block has 8 pages, and each page has 16 bytes. A requester raises `req` with its command and holds it until `done` pulses. `denied` pulses together with `done` when the command broke the rights and so was not performed. A separate select input (`prot`) points the command at the protection page instead of the main memory.

Top module: `dual_access_mem`

## Requirements
- R1: Byte address `addr` (10 bits) maps to block `addr[9:7]`, page `addr[6:4]`, byte `addr[3:0]`. A permitted write stores its byte, and a later permitted read of the same address returns it.
- R2: At most one port holds a grant. A granted port keeps `gnt` high from the cycle after its request is taken until the cycle its `done` pulses. A request from the other port during that time waits.
- R3: When both ports request in the same idle cycle, the serial bus port wins the first such contest after reset. After every grant, priority passes to the port that was not granted.
- R4: RF rights for block b sit in bits [2b+1:2b] of the 16-bit little-endian value in protection bytes 0 and 1. Codes 00 and 01 deny all access, 10 allows reads only, and 11 allows reads and writes.
- R5: Serial bus rights use the same encoding and layout in protection bytes 2 and 3, and they govern that port's main memory accesses.
- R6: Bit p of protection byte 4 blocks writes from either port to page p of block 0. Reads of that page are not affected.
- R7: With `prot`=1, `addr[3:0]` selects a protection byte. The serial bus port may always read and write it. Every RF access to it is denied and changes nothing.
- R8: Bit 0 of protection byte 5 is the tamper flag. Every permitted RF main memory read or write sets it. A serial write can clear it by writing 0, but writing 1 leaves it unchanged. The other bits of byte 5 store as written.
- R9: A denied command pulses `done` and `denied` for one cycle, two clock edges after the request is taken, and leaves memory unchanged. A permitted command pulses `done` three edges after the request is taken, with read data valid on `rdata` in that same cycle.
- R10: After reset, all `gnt`, `done` and `denied` outputs are 0. Protection bytes 0 to 3 read 0xFF, and bytes 4 and 5 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rf_req | input | 1 | RF port request, held until done |
| rf_we | input | 1 | RF write (1) or read (0) |
| rf_prot | input | 1 | RF command targets the protection page |
| rf_addr | input | 10 | RF byte address |
| rf_wdata | input | 8 | RF write data |
| rf_gnt | output | 1 | RF port holds the memory |
| rf_done | output | 1 | RF command complete pulse |
| rf_denied | output | 1 | RF command refused pulse |
| rf_rdata | output | 8 | RF read data |
| sb_req | input | 1 | Serial bus port request, held until done |
| sb_we | input | 1 | Serial bus write (1) or read (0) |
| sb_prot | input | 1 | Serial bus command targets the protection page |
| sb_addr | input | 10 | Serial bus byte address |
| sb_wdata | input | 8 | Serial bus write data |
| sb_gnt | output | 1 | Serial bus port holds the memory |
| sb_done | output | 1 | Serial bus command complete pulse |
| sb_denied | output | 1 | Serial bus command refused pulse |
| sb_rdata | output | 8 | Serial bus read data |

## Verification
Two functions can fall into the same cycle: arbitration between two fresh requests, and the priority update that follows each grant. The bench raises both requests on the same clock edge twice. The first time is right after reset. The second time follows a lone serial command, so priority has moved to the RF port. Each contest is judged by the completion latency of each port: 3 edges for the winner and 6 for the loser. The written bytes are then read back to confirm that both commands completed. A rights sweep over every block, rights code and port checks the denied flag, the latency and the memory contents against a model built from the rules above.

// File: rtl/dam_pkg.sv
package dam_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EXEC = 2'd1,
    ST_RESP = 2'd2
  } seq_state_t;

  // rights codes
  localparam logic [1:0] RIGHT_RO = 2'b10;
  localparam logic [1:0] RIGHT_RW = 2'b11;
endpackage

// File: rtl/dam_ram.sv
module dam_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 1024,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/dam_prot_page.sv
module dam_prot_page #(
  parameter int DATA_W          = 8,
  parameter int NUM_BLOCKS      = 8,
  parameter int PAGES_PER_BLOCK = 8,
  parameter int PAGE_BYTES      = 16,
  parameter int IDX_W           = $clog2(PAGE_BYTES),
  parameter int RIGHTS_W        = 2 * NUM_BLOCKS
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [IDX_W-1:0]           idx,
  input  logic [DATA_W-1:0]          wdata,
  input  logic                       set_tamper,
  output logic [DATA_W-1:0]          rdata,
  output logic [RIGHTS_W-1:0]        rf_rights,
  output logic [RIGHTS_W-1:0]        sb_rights,
  output logic [PAGES_PER_BLOCK-1:0] wp,
  output logic                       tamper
);
  localparam int RIGHTS_BYTES = (RIGHTS_W + DATA_W - 1) / DATA_W;
  localparam int SB_BASE      = RIGHTS_BYTES;
  localparam int WP_BYTE      = 2 * RIGHTS_BYTES;
  localparam int TAMPER_BYTE  = WP_BYTE + 1;
  localparam logic [IDX_W-1:0] TAMPER_IDX = IDX_W'(TAMPER_BYTE);

  logic [DATA_W-1:0] pg [PAGE_BYTES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        pg[i] <= (i < WP_BYTE) ? '1 : '0;
      rdata <= '0;
    end else begin
      if (wr_en) begin
        if (idx == TAMPER_IDX)
          pg[idx] <= {wdata[DATA_W-1:1], wdata[0] & pg[idx][0]};
        else
          pg[idx] <= wdata;
      end
      if (set_tamper) pg[TAMPER_BYTE][0] <= 1'b1;
      if (rd_en) rdata <= pg[idx];
    end
  end

  for (genvar b = 0; b < RIGHTS_W; b++) begin : g_rights
    assign rf_rights[b] = pg[b / DATA_W][b % DATA_W];
    assign sb_rights[b] = pg[SB_BASE + b / DATA_W][b % DATA_W];
  end

  for (genvar p = 0; p < PAGES_PER_BLOCK; p++) begin : g_wp
    assign wp[p] = pg[WP_BYTE][p];
  end

  assign tamper = pg[TAMPER_BYTE][0];

  // R8
  tamper_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(tamper) |-> $past(wr_en && (idx == TAMPER_IDX)));

  // R8
  tamper_set_chk: assert property (@(posedge clk) disable iff (rst)
    set_tamper |=> tamper);
endmodule

// File: rtl/dam_arbiter.sv
module dam_arbiter (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] req,
  input  logic       fire,
  output logic       win
);
  logic prio;

  always_comb begin
    if (req[0] && req[1]) win = prio;
    else                  win = req[1];
  end

  always_ff @(posedge clk) begin
    if (rst)       prio <= 1'b1;
    else if (fire) prio <= ~win;
  end

  // R3
  prio_swap_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> (prio != $past(win)));
endmodule

// File: rtl/dam_access_check.sv
module dam_access_check #(
  parameter int NUM_BLOCKS      = 8,
  parameter int PAGES_PER_BLOCK = 8,
  parameter int PG_W            = $clog2(PAGES_PER_BLOCK),
  parameter int BLK_W           = $clog2(NUM_BLOCKS),
  parameter int RIGHTS_W        = 2 * NUM_BLOCKS
) (
  input  logic                       port_sb,
  input  logic                       we,
  input  logic                       prot,
  input  logic [BLK_W+PG_W-1:0]      page_addr,
  input  logic [RIGHTS_W-1:0]        rf_rights,
  input  logic [RIGHTS_W-1:0]        sb_rights,
  input  logic [PAGES_PER_BLOCK-1:0] wp,
  output logic                       allow
);
  import dam_pkg::*;

  logic [BLK_W-1:0] blk;
  logic [PG_W-1:0]  pg;
  logic [1:0]       field;
  logic             locked;

  assign blk    = page_addr[PG_W +: BLK_W];
  assign pg     = page_addr[PG_W-1:0];
  assign field  = port_sb ? sb_rights[{blk, 1'b0} +: 2] : rf_rights[{blk, 1'b0} +: 2];
  assign locked = (blk == '0) && wp[pg];

  always_comb begin
    if (prot)    allow = port_sb;
    else if (we) allow = (field == RIGHT_RW) && !locked;
    else         allow = field[1];
  end
endmodule

// File: rtl/dual_access_mem.sv
module dual_access_mem #(
  parameter int DATA_W          = 8,
  parameter int NUM_BLOCKS      = 8,
  parameter int PAGES_PER_BLOCK = 8,
  parameter int PAGE_BYTES      = 16,
  localparam int ADDR_W         = $clog2(NUM_BLOCKS * PAGES_PER_BLOCK * PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rf_req,
  input  logic              rf_we,
  input  logic              rf_prot,
  input  logic [ADDR_W-1:0] rf_addr,
  input  logic [DATA_W-1:0] rf_wdata,
  output logic              rf_gnt,
  output logic              rf_done,
  output logic              rf_denied,
  output logic [DATA_W-1:0] rf_rdata,
  input  logic              sb_req,
  input  logic              sb_we,
  input  logic              sb_prot,
  input  logic [ADDR_W-1:0] sb_addr,
  input  logic [DATA_W-1:0] sb_wdata,
  output logic              sb_gnt,
  output logic              sb_done,
  output logic              sb_denied,
  output logic [DATA_W-1:0] sb_rdata
);
  import dam_pkg::*;

  localparam int MEM_BYTES = NUM_BLOCKS * PAGES_PER_BLOCK * PAGE_BYTES;
  localparam int IDX_W     = $clog2(PAGE_BYTES);
  localparam int PG_W      = $clog2(PAGES_PER_BLOCK);
  localparam int BLK_W     = $clog2(NUM_BLOCKS);
  localparam int RIGHTS_W  = 2 * NUM_BLOCKS;

  seq_state_t        state_q;
  logic              owner_q;
  logic              cmd_we_q, cmd_prot_q;
  logic [ADDR_W-1:0] cmd_addr_q;
  logic [DATA_W-1:0] cmd_wdata_q;
  logic [1:0]        gnt_q, done_q, denied_q;
  logic [DATA_W-1:0] rf_rdata_q, sb_rdata_q;

  logic [1:0]                 req_v;
  logic                       win, fire, allow, exec;
  logic                       ram_we, ram_re, prot_we, prot_re, set_tamper;
  logic [DATA_W-1:0]          ram_rd, prot_rd, rd_mux;
  logic [RIGHTS_W-1:0]        rf_rights, sb_rights;
  logic [PAGES_PER_BLOCK-1:0] wp_v;
  logic                       tamper;

  assign req_v = {sb_req, rf_req};
  assign fire  = (state_q == ST_IDLE) && (req_v != 2'b00);
  assign exec  = (state_q == ST_EXEC) && allow;

  assign ram_we     = exec &&  cmd_we_q && !cmd_prot_q;
  assign ram_re     = exec && !cmd_we_q && !cmd_prot_q;
  assign prot_we    = exec &&  cmd_we_q &&  cmd_prot_q;
  assign prot_re    = exec && !cmd_we_q &&  cmd_prot_q;
  assign set_tamper = exec && !owner_q && !cmd_prot_q;
  assign rd_mux     = cmd_prot_q ? prot_rd : ram_rd;

  dam_arbiter u_arb (
    .clk (clk),
    .rst (rst),
    .req (req_v),
    .fire(fire),
    .win (win)
  );

  dam_access_check #(
    .NUM_BLOCKS     (NUM_BLOCKS),
    .PAGES_PER_BLOCK(PAGES_PER_BLOCK)
  ) u_chk (
    .port_sb  (owner_q),
    .we       (cmd_we_q),
    .prot     (cmd_prot_q),
    .page_addr(cmd_addr_q[ADDR_W-1:IDX_W]),
    .rf_rights(rf_rights),
    .sb_rights(sb_rights),
    .wp       (wp_v),
    .allow    (allow)
  );

  dam_prot_page #(
    .DATA_W         (DATA_W),
    .NUM_BLOCKS     (NUM_BLOCKS),
    .PAGES_PER_BLOCK(PAGES_PER_BLOCK),
    .PAGE_BYTES     (PAGE_BYTES)
  ) u_prot (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (prot_we),
    .rd_en     (prot_re),
    .idx       (cmd_addr_q[IDX_W-1:0]),
    .wdata     (cmd_wdata_q),
    .set_tamper(set_tamper),
    .rdata     (prot_rd),
    .rf_rights (rf_rights),
    .sb_rights (sb_rights),
    .wp        (wp_v),
    .tamper    (tamper)
  );

  dam_ram #(
    .DATA_W(DATA_W),
    .DEPTH (MEM_BYTES)
  ) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .re   (ram_re),
    .addr (cmd_addr_q),
    .wdata(cmd_wdata_q),
    .rdata(ram_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      owner_q     <= 1'b0;
      cmd_we_q    <= 1'b0;
      cmd_prot_q  <= 1'b0;
      cmd_addr_q  <= '0;
      cmd_wdata_q <= '0;
      gnt_q       <= '0;
      done_q      <= '0;
      denied_q    <= '0;
      rf_rdata_q  <= '0;
      sb_rdata_q  <= '0;
    end else begin
      done_q   <= '0;
      denied_q <= '0;
      unique case (state_q)
        ST_IDLE: begin
          if (fire) begin
            state_q     <= ST_EXEC;
            owner_q     <= win;
            gnt_q       <= win ? 2'b10 : 2'b01;
            cmd_we_q    <= win ? sb_we    : rf_we;
            cmd_prot_q  <= win ? sb_prot  : rf_prot;
            cmd_addr_q  <= win ? sb_addr  : rf_addr;
            cmd_wdata_q <= win ? sb_wdata : rf_wdata;
          end
        end
        ST_EXEC: begin
          if (allow) begin
            state_q <= ST_RESP;
          end else begin
            state_q           <= ST_IDLE;
            gnt_q             <= '0;
            done_q[owner_q]   <= 1'b1;
            denied_q[owner_q] <= 1'b1;
          end
        end
        ST_RESP: begin
          state_q         <= ST_IDLE;
          gnt_q           <= '0;
          done_q[owner_q] <= 1'b1;
          if (!cmd_we_q) begin
            if (owner_q) sb_rdata_q <= rd_mux;
            else         rf_rdata_q <= rd_mux;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rf_gnt    = gnt_q[0];
  assign sb_gnt    = gnt_q[1];
  assign rf_done   = done_q[0];
  assign sb_done   = done_q[1];
  assign rf_denied = denied_q[0];
  assign sb_denied = denied_q[1];
  assign rf_rdata  = rf_rdata_q;
  assign sb_rdata  = sb_rdata_q;

  // R2
  gnt_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_q));

  // R2
  grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (gnt_q != 2'b00) |=> ((gnt_q == $past(gnt_q)) || (done_q == $past(gnt_q))));

  // R9
  deny_done_chk: assert property (@(posedge clk) disable iff (rst)
    (denied_q != 2'b00) |-> (denied_q == done_q));

  // R9
  deny_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    (denied_q != 2'b00) |-> (!$past(ram_we) && !$past(prot_we) && !$past(set_tamper)));

  // R7
  rf_prot_deny_chk: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_EXEC) && !owner_q && cmd_prot_q) |-> !allow);

  // R6
  wp_lock_chk: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_EXEC) && cmd_we_q && !cmd_prot_q &&
     (cmd_addr_q[ADDR_W-1 -: BLK_W] == '0) && wp_v[cmd_addr_q[IDX_W +: PG_W]]) |-> !allow);
endmodule

// File: tb/sim_dual_access_mem.sv
module sim_dual_access_mem;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rf_req = 0, rf_we = 0, rf_prot = 0;
  logic [9:0] rf_addr = '0;
  logic [7:0] rf_wdata = '0;
  logic       sb_req = 0, sb_we = 0, sb_prot = 0;
  logic [9:0] sb_addr = '0;
  logic [7:0] sb_wdata = '0;
  logic       rf_gnt, rf_done, rf_denied, sb_gnt, sb_done, sb_denied;
  logic [7:0] rf_rdata, sb_rdata;

  int nchecks = 0;
  int nfail   = 0;

  logic [7:0] mem_m  [1024];
  logic [7:0] prot_m [16];

  always #2 clk = ~clk;

  dual_access_mem u0 (
    .clk(clk), .rst(rst),
    .rf_req(rf_req), .rf_we(rf_we), .rf_prot(rf_prot), .rf_addr(rf_addr),
    .rf_wdata(rf_wdata), .rf_gnt(rf_gnt), .rf_done(rf_done),
    .rf_denied(rf_denied), .rf_rdata(rf_rdata),
    .sb_req(sb_req), .sb_we(sb_we), .sb_prot(sb_prot), .sb_addr(sb_addr),
    .sb_wdata(sb_wdata), .sb_gnt(sb_gnt), .sb_done(sb_done),
    .sb_denied(sb_denied), .sb_rdata(sb_rdata)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    nchecks++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit allowed(input bit port, input bit we, input bit prot, input int addr);
    int blk, pg;
    logic [15:0] rr;
    logic [1:0] f;
    blk = addr / 128;
    pg  = (addr / 16) % 8;
    rr  = port ? {prot_m[3], prot_m[2]} : {prot_m[1], prot_m[0]};
    f   = rr[2*blk +: 2];
    if (prot) return port;
    if (we)   return (f == 2'b11) && !((blk == 0) && prot_m[4][pg]);
    return f[1];
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 16; i++) prot_m[i] = (i < 4) ? 8'hFF : 8'h00;
  endtask

  // port: 0 = RF, 1 = serial bus
  task automatic op(input bit port, input bit we, input bit prot, input int addr,
                    input logic [7:0] wd, input string tag, input bit solo, output int lat);
    bit ok_e, dn, dd, g;
    logic [7:0] exp_rd, rd;
    int cnt, gcnt, idx;
    ok_e   = allowed(port, we, prot, addr);
    exp_rd = prot ? prot_m[addr % 16] : mem_m[addr];
    @(negedge clk);
    if (port) begin
      sb_req = 1; sb_we = we; sb_prot = prot; sb_addr = 10'(addr); sb_wdata = wd;
    end else begin
      rf_req = 1; rf_we = we; rf_prot = prot; rf_addr = 10'(addr); rf_wdata = wd;
    end
    cnt = 0; gcnt = 0; dn = 0; dd = 0; rd = '0;
    while (!dn && cnt < 40) begin
      @(negedge clk);
      cnt++;
      g  = port ? sb_gnt    : rf_gnt;
      dn = port ? sb_done   : rf_done;
      dd = port ? sb_denied : rf_denied;
      rd = port ? sb_rdata  : rf_rdata;
      if (g) gcnt++;
    end
    if (port) sb_req = 0; else rf_req = 0;
    lat = cnt;
    chk(dn, tag, "done seen", dn, 1);
    chk(dd == !ok_e, tag, "denied", dd, !ok_e);
    if (solo) begin
      // R9 latency: 2 edges when denied, 3 when permitted
      chk(cnt == (ok_e ? 3 : 2), "R9", "latency", cnt, ok_e ? 3 : 2);
      // R2 grant held through the operation
      chk(gcnt == (ok_e ? 2 : 1), "R2", "grant cycles", gcnt, ok_e ? 2 : 1);
    end
    if (!we && ok_e) chk(rd === exp_rd, tag, "read data", rd, exp_rd);
    if (ok_e) begin
      if (we) begin
        if (prot) begin
          idx = addr % 16;
          if (idx == 5) prot_m[5] = {wd[7:1], wd[0] & prot_m[5][0]};
          else          prot_m[idx] = wd;
        end else begin
          mem_m[addr] = wd;
        end
      end
      if (!port && !prot) prot_m[5][0] = 1'b1;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    model_reset();
  endtask

  task automatic set_rights(input bit port, input logic [15:0] v);
    int l;
    op(1, 1, 1, port ? 2 : 0, v[7:0],  port ? "R5" : "R4", 1, l);
    op(1, 1, 1, port ? 3 : 1, v[15:8], port ? "R5" : "R4", 1, l);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog R9 act=%0d exp=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end

  initial begin
    int l, l1, l2, a;
    string tg;
    logic [15:0] rv;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 outputs idle after reset
    chk(rf_gnt == 0,    "R10", "rf_gnt",    rf_gnt, 0);
    chk(sb_gnt == 0,    "R10", "sb_gnt",    sb_gnt, 0);
    chk(rf_done == 0,   "R10", "rf_done",   rf_done, 0);
    chk(sb_done == 0,   "R10", "sb_done",   sb_done, 0);
    chk(rf_denied == 0, "R10", "rf_denied", rf_denied, 0);
    chk(sb_denied == 0, "R10", "sb_denied", sb_denied, 0);

    // R3 first contest after reset: serial bus wins
    fork
      op(1, 1, 0, 900, 8'h5A, "R3", 0, l1);
      op(0, 1, 0, 901, 8'hA5, "R3", 0, l2);
    join
    chk(l1 == 3, "R3", "sb latency tie1", l1, 3);
    chk(l2 == 6, "R3", "rf latency tie1", l2, 6);
    op(1, 1, 0, 902, 8'h11, "R3", 1, l);
    // R3 after a serial grant, RF holds priority
    fork
      op(1, 1, 0, 903, 8'h22, "R3", 0, l1);
      op(0, 1, 0, 904, 8'h33, "R3", 0, l2);
    join
    chk(l2 == 3, "R3", "rf latency tie2", l2, 3);
    chk(l1 == 6, "R3", "sb latency tie2", l1, 6);
    for (int i = 900; i < 905; i++) op(1, 0, 0, i, 8'h00, "R2", 1, l);

    // R10 protection page defaults, tamper cleared by reset
    do_reset();
    for (int i = 0; i < 6; i++) op(1, 0, 1, i, 8'h00, "R10", 1, l);

    // R1 exhaustive fill and read back
    for (int i = 0; i < 1024; i++) op(1, 1, 0, i, 8'(i * 37 + (i >> 5)), "R1", 1, l);
    for (int i = 0; i < 1024; i++) op(1, 0, 0, i, 8'h00, "R1", 1, l);

    // R6 lock pages 1 and 3 of block 0
    op(1, 1, 1, 4, 8'h0A, "R6", 1, l);

    // R4 / R5 rights sweep over port, block and code
    for (int port = 0; port < 2; port++) begin
      for (int b = 0; b < 8; b++) begin
        for (int r = 0; r < 4; r++) begin
          rv = 16'hFFFF;
          rv[2*b +: 2] = 2'(r);
          set_rights(port[0], rv);
          for (int p = 1; p < 3; p++) begin
            a  = b * 128 + p * 16 + r * 3 + port;
            tg = (b == 0 && p == 1) ? "R6" : (port != 0) ? "R5" : "R4";
            op(port[0], 1, 0, a, 8'(a ^ (r << 4) ^ 8'h96), tg, 1, l);
            op(port[0], 0, 0, a, 8'h00, tg, 1, l);
          end
          set_rights(port[0], 16'hFFFF);
          for (int p = 1; p < 3; p++)
            op(1, 0, 0, b * 128 + p * 16 + r * 3 + port, 8'h00, "R9", 1, l);
        end
      end
    end

    // R7 RF cannot touch the protection page
    op(0, 0, 1, 3, 8'h00, "R7", 1, l);
    op(0, 1, 1, 4, 8'h00, "R7", 1, l);
    op(1, 0, 1, 4, 8'h00, "R7", 1, l);
    op(1, 1, 1, 9, 8'h3C, "R7", 1, l);
    op(1, 0, 1, 9, 8'h00, "R7", 1, l);

    // R8 tamper flag rules
    op(1, 0, 1, 5, 8'h00, "R8", 1, l);
    op(1, 1, 1, 5, 8'hF0, "R8", 1, l);
    op(1, 0, 1, 5, 8'h00, "R8", 1, l);
    op(1, 1, 1, 5, 8'hF1, "R8", 1, l);
    op(1, 0, 1, 5, 8'h00, "R8", 1, l);
    op(0, 0, 0, 900, 8'h00, "R8", 1, l);
    op(1, 0, 1, 5, 8'h00, "R8", 1, l);
    op(1, 1, 1, 5, 8'hF0, "R8", 1, l);
    op(1, 1, 1, 1, 8'h3F, "R8", 1, l);
    op(0, 0, 0, 900, 8'h00, "R8", 1, l);
    op(1, 0, 1, 5, 8'h00, "R8", 1, l);
    op(1, 1, 1, 1, 8'hFF, "R8", 1, l);

    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end
endmodule